// File: doc/BRIEF.md
# Linear-Gap Alignment Scoring Cell

This block scores one cell of a two-dimensional dynamic-programming alignment matrix that uses a single linear gap penalty. On each accepted input beat it takes the scores of the three neighbours of the cell (the one above, the one to the left and the one on the diagonal), one query character and one reference character. From these it forms three candidates and picks the best one under a fixed priority. It returns the cell score together with a 2-bit traceback pointer that names the neighbour the score came from.

The match, mismatch and gap values and the mode selection are plain, quasi-static control pins. In global mode the best candidate is passed through unchanged. In local mode a negative best is clamped to zero and marked as a path end. A matrix sweeper feeds cells through a valid/ready stream.

The input beat transfers on a rising edge where `in_valid` and `in_ready` are both high. The result is held in a single output register until `out_valid` and `out_ready` are both high on an edge. `in_ready` is high whenever that register is empty or is being drained in the same cycle, so a full stream moves one cell per cycle. While the output stalls, the result stays frozen and no new input is taken.

Top module: `lin_align_cell`

## Requirements
- R1: The left candidate equals the left neighbour plus `gap_score`, and the up candidate equals the up neighbour plus `gap_score`. Scores are signed 16-bit two's complement, and the penalties are given as negative numbers that are added.
- R2: The diagonal candidate equals the diagonal neighbour plus `match_score` when `qry_char` equals `ref_char`, and plus `mismatch_score` otherwise. Characters are 2-bit codes with A=0, C=1, G=2, T=3.
- R3: The selection starts from the left candidate with pointer LEFT. The diagonal candidate takes over only if it is strictly greater, with pointer DIAG. The up candidate then takes over only if it is strictly greater than the current best, with pointer UP. Ties therefore favour LEFT over DIAG, and DIAG over UP.
- R4: With `local_mode`=1, a best value below zero is output as 0 with pointer END. With `local_mode`=0, negative values pass through unchanged.
- R5: Pointer codes are LEFT=0, DIAG=1, UP=2, END=3. END never appears when `local_mode`=0.
- R6: Every addition saturates at -32768 and +32767 instead of wrapping.
- R7: After reset `out_valid` is 0 and `in_ready` is 1. A beat accepted on an edge appears on the outputs with `out_valid`=1 right after that edge. With `out_ready`=1 and no new input, `out_valid` returns to 0 one edge later.
- R8: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `cell_score` and `cell_ptr` do not change.
- R9: When `out_valid`=1 and `out_ready`=1, `in_ready` is 1. The next beat is taken on the same edge that drains the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_mode | input | 1 | 1 = clamp at zero with END pointer, 0 = no clamp |
| match_score | input | 16 | Signed score added on equal characters |
| mismatch_score | input | 16 | Signed score added on differing characters |
| gap_score | input | 16 | Signed linear gap penalty |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| up_score | input | 16 | Signed score of the cell above |
| left_score | input | 16 | Signed score of the cell to the left |
| diag_score | input | 16 | Signed score of the diagonal cell |
| qry_char | input | 2 | Query character code |
| ref_char | input | 2 | Reference character code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| cell_score | output | 16 | Signed cell score |
| cell_ptr | output | 2 | Traceback pointer |

## Verification
The scoring path has no state, so a wrong candidate, a misordered comparison or a wrapped sum appears in the result of the very beat that triggered it, one edge after acceptance. A sweep over small neighbour values, every character pair, both modes and two parameter sets therefore exposes every tie order and sign crossing within one cycle. The only state is the output register and its valid flag. A fault there shows as a lost, duplicated or altered result during a stall, or as a wrong `in_ready` level, and the directed back-pressure sequence observes it within two edges.

// File: rtl/dp_cell_pkg.sv
package dp_cell_pkg;

  typedef enum logic [1:0] {
    PTR_LEFT = 2'd0,
    PTR_DIAG = 2'd1,
    PTR_UP   = 2'd2,
    PTR_END  = 2'd3
  } tb_dir_e;

  localparam int NUM_CAND = 3;

endpackage

// File: rtl/sat_add.sv
module sat_add #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] sum
);
  localparam logic signed [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0] wide;

  always_comb begin
    wide = {a[W-1], a} + {b[W-1], b};
    if (wide[W] != wide[W-1]) begin
      sum = wide[W] ? S_MIN : S_MAX;
    end else begin
      sum = wide[W-1:0];
    end
  end
endmodule

// File: rtl/cand_gen.sv
module cand_gen #(
  parameter int W  = 16,
  parameter int CW = 2
) (
  input  logic signed [W-1:0]  up_s,
  input  logic signed [W-1:0]  left_s,
  input  logic signed [W-1:0]  diag_s,
  input  logic        [CW-1:0] q_chr,
  input  logic        [CW-1:0] r_chr,
  input  logic signed [W-1:0]  match_s,
  input  logic signed [W-1:0]  mismatch_s,
  input  logic signed [W-1:0]  gap_s,
  output logic signed [W-1:0]  ins_c,
  output logic signed [W-1:0]  del_c,
  output logic signed [W-1:0]  dia_c
);
  import dp_cell_pkg::*;

  logic signed [W-1:0] base_v [NUM_CAND];
  logic signed [W-1:0] addv_v [NUM_CAND];
  logic signed [W-1:0] res_v  [NUM_CAND];
  logic                same_chr;

  assign same_chr  = (q_chr == r_chr);
  assign base_v[0] = left_s;
  assign addv_v[0] = gap_s;
  assign base_v[1] = up_s;
  assign addv_v[1] = gap_s;
  assign base_v[2] = diag_s;
  assign addv_v[2] = same_chr ? match_s : mismatch_s;

  for (genvar k = 0; k < NUM_CAND; k++) begin : g_add
    sat_add #(.W(W)) u_add (
      .a   (base_v[k]),
      .b   (addv_v[k]),
      .sum (res_v[k])
    );
  end

  assign ins_c = res_v[0];
  assign del_c = res_v[1];
  assign dia_c = res_v[2];
endmodule

// File: rtl/best_pick.sv
module best_pick #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] ins_c,
  input  logic signed [W-1:0] del_c,
  input  logic signed [W-1:0] dia_c,
  input  logic                clamp_en,
  output logic signed [W-1:0] best_s,
  output logic        [1:0]   best_p
);
  import dp_cell_pkg::*;

  logic signed [W-1:0] run_s;
  tb_dir_e             run_p;

  always_comb begin
    run_s = ins_c;
    run_p = PTR_LEFT;
    if (dia_c > run_s) begin
      run_s = dia_c;
      run_p = PTR_DIAG;
    end
    if (del_c > run_s) begin
      run_s = del_c;
      run_p = PTR_UP;
    end
    if (clamp_en && run_s[W-1]) begin
      run_s = '0;
      run_p = PTR_END;
    end
    best_s = run_s;
    best_p = run_p;
  end
endmodule

// File: rtl/out_reg.sv
module out_reg #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                d_valid,
  output logic                d_ready,
  input  logic signed [W-1:0] d_score,
  input  logic        [1:0]   d_ptr,
  output logic                q_valid,
  input  logic                q_ready,
  output logic signed [W-1:0] q_score,
  output logic        [1:0]   q_ptr
);
  logic take;

  assign d_ready = !q_valid || q_ready;
  assign take    = d_valid && d_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_score <= '0;
      q_ptr   <= '0;
    end else begin
      if (take) begin
        q_valid <= 1'b1;
        q_score <= d_score;
        q_ptr   <= d_ptr;
      end else if (q_ready) begin
        q_valid <= 1'b0;
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid && d_ready |=> q_valid); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && !q_ready |=> q_valid && $stable(q_score) && $stable(q_ptr)); // R8

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && q_ready && !d_valid |=> !q_valid); // R7
endmodule

// File: rtl/lin_align_cell.sv
module lin_align_cell #(
  parameter int SCORE_W = 16,
  parameter int CHAR_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      local_mode,
  input  logic signed [SCORE_W-1:0] match_score,
  input  logic signed [SCORE_W-1:0] mismatch_score,
  input  logic signed [SCORE_W-1:0] gap_score,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic signed [SCORE_W-1:0] up_score,
  input  logic signed [SCORE_W-1:0] left_score,
  input  logic signed [SCORE_W-1:0] diag_score,
  input  logic        [CHAR_W-1:0]  qry_char,
  input  logic        [CHAR_W-1:0]  ref_char,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic signed [SCORE_W-1:0] cell_score,
  output logic        [1:0]         cell_ptr
);
  import dp_cell_pkg::*;

  logic signed [SCORE_W-1:0] ins_c, del_c, dia_c;
  logic signed [SCORE_W-1:0] sel_score;
  logic        [1:0]         sel_ptr;

  cand_gen #(.W(SCORE_W), .CW(CHAR_W)) u_cand (
    .up_s       (up_score),
    .left_s     (left_score),
    .diag_s     (diag_score),
    .q_chr      (qry_char),
    .r_chr      (ref_char),
    .match_s    (match_score),
    .mismatch_s (mismatch_score),
    .gap_s      (gap_score),
    .ins_c      (ins_c),
    .del_c      (del_c),
    .dia_c      (dia_c)
  );

  best_pick #(.W(SCORE_W)) u_pick (
    .ins_c    (ins_c),
    .del_c    (del_c),
    .dia_c    (dia_c),
    .clamp_en (local_mode),
    .best_s   (sel_score),
    .best_p   (sel_ptr)
  );

  out_reg #(.W(SCORE_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (in_valid),
    .d_ready (in_ready),
    .d_score (sel_score),
    .d_ptr   (sel_ptr),
    .q_valid (out_valid),
    .q_ready (out_ready),
    .q_score (cell_score),
    .q_ptr   (cell_ptr)
  );

  AST_DIAG_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ptr == PTR_DIAG |-> sel_score > ins_c); // R3

  AST_UP_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ptr == PTR_UP |-> sel_score > ins_c && sel_score > dia_c); // R3

  AST_LOCAL_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    local_mode |-> !sel_score[SCORE_W-1]); // R4

  AST_NO_END_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    !local_mode |-> sel_ptr != PTR_END); // R5
endmodule

// File: tb/lin_align_cell_test.sv
`timescale 1ns/1ps
module lin_align_cell_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic local_mode = 1'b0;
  logic signed [15:0] match_score = 16'sd2;
  logic signed [15:0] mismatch_score = -16'sd1;
  logic signed [15:0] gap_score = -16'sd2;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] up_score = '0, left_score = '0, diag_score = '0;
  logic [1:0] qry_char = '0, ref_char = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [15:0] cell_score;
  logic [1:0] cell_ptr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lin_align_cell uut (
    .clk(clk), .rst_n(rst_n), .local_mode(local_mode),
    .match_score(match_score), .mismatch_score(mismatch_score), .gap_score(gap_score),
    .in_valid(in_valid), .in_ready(in_ready),
    .up_score(up_score), .left_score(left_score), .diag_score(diag_score),
    .qry_char(qry_char), .ref_char(ref_char),
    .out_valid(out_valid), .out_ready(out_ready),
    .cell_score(cell_score), .cell_ptr(cell_ptr)
  );

  function automatic int sat(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // expected score and pointer from the requirements
  function automatic void model(input int u, input int l, input int d, input int q, input int r,
                                output int es, output int ep);
    int ic, dc, gc;
    ic = sat(l + int'(gap_score));
    dc = sat(u + int'(gap_score));
    gc = sat(d + ((q == r) ? int'(match_score) : int'(mismatch_score)));
    es = ic; ep = 0;
    if (gc > es) begin es = gc; ep = 1; end
    if (dc > es) begin es = dc; ep = 2; end
    if (local_mode && es < 0) begin es = 0; ep = 3; end
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int u, input int l, input int d, input int q, input int r);
    up_score = 16'(u); left_score = 16'(l); diag_score = 16'(d);
    qry_char = 2'(q); ref_char = 2'(r);
    in_valid = 1'b1;
  endtask

  // drive one beat with out_ready high and check its result one edge later
  task automatic run_beat(input string tag, input int u, input int l, input int d,
                          input int q, input int r);
    int es, ep;
    @(negedge clk);
    drive(u, l, d, q, r);
    model(u, l, d, q, r, es, ep);
    @(negedge clk);
    chk({tag, " score"}, int'(cell_score), es);
    chk({tag, " ptr"}, int'(cell_ptr), ep);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #25;
    chk("R7 reset out_valid", int'(out_valid), 0);
    chk("R7 reset in_ready", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R7 latency and drain
    @(negedge clk);
    drive(0, 4, 0, 0, 0);
    @(negedge clk);
    chk("R7 valid after accept", int'(out_valid), 1);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7 valid drops", int'(out_valid), 0);

    // R1 R2 R3 R4 R5 sweep: both param sets, both modes
    for (int ps = 0; ps < 2; ps++) begin
      match_score    = (ps == 0) ? 16'sd2  : 16'sd1;
      mismatch_score = (ps == 0) ? -16'sd1 : -16'sd3;
      gap_score      = (ps == 0) ? -16'sd2 : -16'sd1;
      for (int m = 0; m < 2; m++) begin
        local_mode = m[0];
        for (int u = -3; u <= 3; u++)
          for (int l = -3; l <= 3; l++)
            for (int d = -3; d <= 3; d++)
              for (int q = 0; q < 4; q++)
                for (int r = 0; r < 4; r++)
                  run_beat("R1 R2 R3 R4 R5 sweep", u, l, d, q, r);
      end
    end

    match_score = 16'sd2; mismatch_score = -16'sd1; gap_score = -16'sd2;
    local_mode = 1'b0;
    // R3 ties: left vs diag, diag vs up
    run_beat("R3 tie left-diag", 0, 2, 0, 1, 1);   // ins 0, dia 2? left 2+(-2)=0, diag 0+2=2 -> DIAG
    run_beat("R3 tie left-diag eq", -9, 4, 0, 1, 1); // ins 2, dia 2 -> LEFT
    run_beat("R3 tie diag-up eq", 4, -9, 0, 1, 1);   // dia 2, del 2 -> DIAG
    // R2 match vs mismatch on same neighbours
    run_beat("R2 match", -9, -9, 5, 2, 2);
    run_beat("R2 mismatch", -9, -9, 5, 3, 0);
    // R4 local clamp and global pass-through
    local_mode = 1'b1;
    run_beat("R4 local clamp", -5, -5, -5, 0, 1);
    local_mode = 1'b0;
    run_beat("R4 global negative", -5, -5, -5, 0, 1);
    // R6 saturation high and low
    gap_score = 16'sd5;
    run_beat("R6 sat high", 0, 32767, 0, 0, 1);
    gap_score = -16'sd5; mismatch_score = -16'sd5;
    run_beat("R6 sat low", -32768, -32768, -32768, 0, 1);
    gap_score = -16'sd2; mismatch_score = -16'sd1;

    // R8 R9 back-pressure
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    drive(0, 10, 0, 0, 0);   // A: ins 8, LEFT
    out_ready = 1'b0;
    @(negedge clk);
    chk("R8 A valid", int'(out_valid), 1);
    chk("R8 A score", int'(cell_score), 8);
    chk("R8 stall in_ready", int'(in_ready), 0);
    drive(0, 20, 0, 0, 0);   // B: ins 18
    @(negedge clk);
    chk("R8 hold score", int'(cell_score), 8);
    chk("R8 hold ptr", int'(cell_ptr), 0);
    chk("R8 hold valid", int'(out_valid), 1);
    out_ready = 1'b1;
    #1;
    chk("R9 ready while draining", int'(in_ready), 1);
    @(negedge clk);
    chk("R9 B taken on drain edge", int'(cell_score), 18);
    chk("R9 B valid", int'(out_valid), 1);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7 idle after B", int'(out_valid), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule